// File: doc/BRIEF.md
# Vectored Interrupt Priority Arbiter

This block gathers the interrupt request lines of several peripherals into one interrupt line for a processor. While any channel that software has unmasked is requesting and the arbiter is switched on, the interrupt line is high. When the processor raises its acknowledge input, the arbiter picks one pending channel. It sends an acknowledge pulse back to that channel alone, and it drives that channel's programmed 8-bit table index onto the read data bus. The processor uses that byte to look up a service routine in a table of up to 256 entries, so a routine can move without any change to the peripheral.

Software sets up the arbiter through a small byte-wide register file on the processor bus. Offset 0 is the channel mask. Offsets 1 to NUM_CH hold the per-channel table indices, with channel i at offset i+1. Offset NUM_CH+1 is the control register. In the control register, bit 0 is the global enable and bit 1 selects rotating priority in place of fixed priority. Reads are combinational. The data output is enabled only during a register read or an acknowledge.

Top module: `irq_vec_arbiter`

## Requirements
- R1: After reset, every register reads 0, and cpu_int, irq_ack and bus_oe are low.
- R2: A write at offset 0 sets the mask. A write at offset i+1 sets the index of channel i. A write at offset NUM_CH+1 sets the control bits (bit 0 enable, bit 1 rotate). Each mapped offset reads back what was written, and unmapped offsets read 0.
- R3: cpu_int is high exactly when control bit 0 is 1 and at least one channel has both its request and its mask bit (bit i for channel i) set.
- R4: While control bit 0 is 0, cpu_int stays low whatever the requests, and an acknowledge selects no channel.
- R5: With control bit 1 at 0, the lowest-numbered pending unmasked channel wins.
- R6: With control bit 1 at 1, the search starts at the channel after the one served last and wraps around. After reset, channel 0 comes first.
- R7: One clock after cpu_inta is first sampled high, exactly one ack bit is high, for the winner. In the same cycle bus_rdata carries the winner's index and bus_oe is high. All three hold while cpu_inta stays high.
- R8: Request changes while cpu_inta is high do not change the chosen channel, its ack or the driven index.
- R9: One clock after cpu_inta is sampled low, all ack bits are low, and bus_oe is low unless a read is under way.
- R10: An acknowledge with no pending unmasked channel raises no ack bit and drives 0 with bus_oe high.
- R11: A channel whose mask bit is 0 is never chosen, even when it requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, or table index during acknowledge |
| bus_oe | output | 1 | Data output enable |
| irq_req | input | NUM_CH | Peripheral request lines |
| irq_ack | output | NUM_CH | Per-channel acknowledge |
| cpu_int | output | 1 | Interrupt to processor |
| cpu_inta | input | 1 | Interrupt acknowledge from processor |

## Verification
The bench builds the arbiter with NUM_CH=4 and ADDR_W=4. With four channels the rotating search has to wrap past the highest channel, and it visits channels that are neither first nor last. The mask can also hide a middle channel while a lower one is still requesting. Four channels also move the control register to offset 5, which checks the offset arithmetic for the index registers rather than the two-channel layout.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    typedef logic [7:0] byte_t;
    localparam int CTRL_EN = 0;
    localparam int CTRL_RR = 1;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_arb_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr,
    input  logic [ADDR_W-1:0]      addr,
    input  byte_t                  wdata,
    output logic [NUM_CH-1:0]      mask,
    output logic [NUM_CH-1:0][7:0] idx,
    output logic                   en,
    output logic                   rr,
    output byte_t                  rdata
);
    localparam int CTRL_OFS = NUM_CH + 1;

    typedef struct packed {
        logic [NUM_CH-1:0]      mask;
        logic [NUM_CH-1:0][7:0] idx;
        logic [1:0]             ctrl;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        rdata = '0;
        if (addr == ADDR_W'(0)) rdata = byte_t'(cfg_q.mask);
        if (addr == ADDR_W'(CTRL_OFS)) rdata = byte_t'(cfg_q.ctrl);
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == ADDR_W'(i + 1)) rdata = cfg_q.idx[i];
        end
        if (wr) begin
            if (addr == ADDR_W'(0)) cfg_d.mask = wdata[NUM_CH-1:0];
            if (addr == ADDR_W'(CTRL_OFS)) cfg_d.ctrl = wdata[1:0];
            for (int i = 0; i < NUM_CH; i++) begin
                if (addr == ADDR_W'(i + 1)) cfg_d.idx[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign mask = cfg_q.mask;
    assign idx  = cfg_q.idx;
    assign en   = cfg_q.ctrl[CTRL_EN];
    assign rr   = cfg_q.ctrl[CTRL_RR];
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int NUM_CH = 2,
    parameter int CH_W   = 1
) (
    input  logic [NUM_CH-1:0] pend,
    input  logic              rr,
    input  logic [CH_W-1:0]   last,
    output logic              hit,
    output logic [CH_W-1:0]   win
);
    always_comb begin
        int start;
        int pos;
        hit = 1'b0;
        win = '0;
        start = 0;
        if (rr) start = (int'(last) >= NUM_CH - 1) ? 0 : int'(last) + 1;
        for (int k = 0; k < NUM_CH; k++) begin
            pos = start + k;
            if (pos >= NUM_CH) pos = pos - NUM_CH;
            if (!hit && pend[pos]) begin
                hit = 1'b1;
                win = CH_W'(pos);
            end
        end
    end
endmodule

// File: rtl/irq_vec_arbiter.sv
module irq_vec_arbiter
    import irq_arb_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              bus_oe,
    input  logic [NUM_CH-1:0] irq_req,
    output logic [NUM_CH-1:0] irq_ack,
    output logic              cpu_int,
    input  logic              cpu_inta
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    typedef struct packed {
        logic            inta_prev;
        logic            busy;
        logic            hit;
        logic [CH_W-1:0] win;
        logic [CH_W-1:0] last;
    } st_t;

    st_t st_d, st_q;

    logic [NUM_CH-1:0]      mask;
    logic [NUM_CH-1:0][7:0] idx;
    logic                   en, rr;
    byte_t                  reg_rdata;
    logic [NUM_CH-1:0]      pend;
    logic                   pick_hit;
    logic [CH_W-1:0]        pick_win;

    irq_cfg_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .mask(mask), .idx(idx), .en(en), .rr(rr),
        .rdata(reg_rdata)
    );

    assign pend    = irq_req & mask & {NUM_CH{en}};
    assign cpu_int = |pend;

    irq_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pick (
        .pend(pend), .rr(rr), .last(st_q.last),
        .hit(pick_hit), .win(pick_win)
    );

    always_comb begin
        st_d = st_q;
        st_d.inta_prev = cpu_inta;
        if (cpu_inta && !st_q.inta_prev) begin
            st_d.busy = 1'b1;
            st_d.hit  = pick_hit;
            st_d.win  = pick_win;
            if (pick_hit) st_d.last = pick_win;
        end else if (!cpu_inta) begin
            st_d.busy = 1'b0;
            st_d.hit  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.last <= CH_W'(NUM_CH - 1);
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ack
        assign irq_ack[g] = st_q.busy && st_q.hit && (st_q.win == CH_W'(g));
    end

    assign bus_oe    = st_q.busy || bus_rd;
    assign bus_rdata = st_q.busy ? (st_q.hit ? idx[st_q.win] : 8'h00)
                     : (bus_rd ? reg_rdata : 8'h00);

    // R7
    ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_ack));

    // R7
    ack_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack != '0) |-> bus_oe);

    // R8
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_inta && $past(cpu_inta) && (irq_ack != '0) && ($past(irq_ack) != '0))
        |-> $stable(irq_ack));

    // R9
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cpu_inta) |-> (irq_ack == '0));
endmodule

// File: tb/irq_vec_arbiter_bench.sv
module irq_vec_arbiter_bench;
    localparam int N  = 4;
    localparam int AW = 4;
    localparam int CTRL = N + 1;

    logic          clk = 0;
    logic          rst_n = 0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 0, bus_rd = 0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic          bus_oe;
    logic [N-1:0]  irq_req = '0;
    logic [N-1:0]  irq_ack;
    logic          cpu_int;
    logic          cpu_inta = 0;

    always #10 clk = ~clk;

    irq_vec_arbiter #(.NUM_CH(N), .ADDR_W(AW)) u_irq_vec_arbiter (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_oe(bus_oe), .irq_req(irq_req), .irq_ack(irq_ack),
        .cpu_int(cpu_int), .cpu_inta(cpu_inta)
    );

    typedef struct {
        logic [N-1:0] ack;
        logic [7:0]   data;
        logic         oe;
        string        tag;
    } exp_t;

    exp_t exp_q[$];
    event chk_ev;
    int   errors = 0;
    int   checks = 0;

    // software-visible model state
    logic [N-1:0] m_mask = '0;
    logic [7:0]   m_idx [N];
    logic [1:0]   m_ctrl = '0;
    int           m_last = N - 1;
    exp_t         cur;

    // monitor: pops the expected acknowledge-cycle outputs and compares
    initial begin
        forever begin
            @(chk_ev);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (irq_ack !== e.ack || bus_rdata !== e.data || bus_oe !== e.oe) begin
                    errors++;
                    $display("FAIL %s: ack=%b data=%0d oe=%b expected ack=%b data=%0d oe=%b",
                             e.tag, irq_ack, bus_rdata, bus_oe, e.ack, e.data, e.oe);
                end
            end
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic int model_win(logic [N-1:0] req);
        logic [N-1:0] p;
        int start;
        p = req & m_mask & {N{m_ctrl[0]}};
        start = m_ctrl[1] ? ((m_last + 1) % N) : 0;
        for (int k = 0; k < N; k++) begin
            if (p[(start + k) % N]) return (start + k) % N;
        end
        return -1;
    endfunction

    task automatic reg_wr(int a, logic [7:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
        if (a == 0) m_mask = d[N-1:0];
        else if (a == CTRL) m_ctrl = d[1:0];
        else if (a <= N) m_idx[a-1] = d;
    endtask

    task automatic reg_rd(int a, logic [7:0] expv, string tag);
        @(negedge clk);
        bus_addr = AW'(a); bus_rd = 1;
        #1;
        check({tag, " rdata"}, 32'(bus_rdata), 32'(expv));
        check({tag, " oe"}, 32'(bus_oe), 32'd1);
        bus_rd = 0;
    endtask

    task automatic int_chk(logic [N-1:0] req, logic expv, string tag);
        @(negedge clk);
        irq_req = req;
        #1;
        check(tag, 32'(cpu_int), 32'(expv));
    endtask

    task automatic ack_begin(logic [N-1:0] req, string tag);
        int w;
        @(negedge clk);
        irq_req = req;
        cpu_inta = 1;
        w = model_win(req);
        cur.tag = tag;
        cur.oe  = 1'b1;
        if (w >= 0) begin
            cur.ack  = N'(1) << w;
            cur.data = m_idx[w];
            m_last   = w;
        end else begin
            cur.ack  = '0;
            cur.data = 8'h00;
        end
        @(negedge clk);
        exp_q.push_back(cur);
        ->chk_ev;
        #1;
    endtask

    task automatic ack_hold(logic [N-1:0] req, string tag);
        @(negedge clk);
        irq_req = req;
        @(negedge clk);
        cur.tag = tag;
        exp_q.push_back(cur);
        ->chk_ev;
        #1;
    endtask

    task automatic ack_end(string tag);
        exp_t e;
        @(negedge clk);
        cpu_inta = 0;
        irq_req = '0;
        @(negedge clk);
        e.ack = '0; e.data = 8'h00; e.oe = 1'b0; e.tag = tag;
        exp_q.push_back(e);
        ->chk_ev;
        #1;
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) m_idx[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 cpu_int", 32'(cpu_int), 32'd0);
        check("R1 irq_ack", 32'(irq_ack), 32'd0);
        check("R1 bus_oe", 32'(bus_oe), 32'd0);
        for (int a = 0; a <= CTRL; a++) reg_rd(a, 8'h00, "R1 reset reg");

        // R2 register map
        reg_wr(0, 8'h0F);
        reg_wr(1, 8'd13);
        reg_wr(2, 8'd17);
        reg_wr(3, 8'd33);
        reg_wr(4, 8'd99);
        reg_wr(CTRL, 8'h01);
        reg_rd(0, 8'h0F, "R2 mask");
        reg_rd(1, 8'd13, "R2 idx0");
        reg_rd(3, 8'd33, "R2 idx2");
        reg_rd(4, 8'd99, "R2 idx3");
        reg_rd(CTRL, 8'h01, "R2 ctrl");
        reg_rd(7, 8'h00, "R2 unmapped");

        // R3 interrupt combine
        int_chk(4'b0000, 1'b0, "R3 no request");
        int_chk(4'b0100, 1'b1, "R3 one request");

        // R4 global enable off
        reg_wr(CTRL, 8'h00);
        int_chk(4'b1111, 1'b0, "R4 disabled int");
        // R10 acknowledge with nothing pending
        ack_begin(4'b1111, "R4 R10 empty ack");
        ack_end("R9 release after empty");

        // R5 fixed priority
        reg_wr(CTRL, 8'h01);
        ack_begin(4'b0110, "R5 fixed ch1");
        // R8 request changes ignored during acknowledge
        ack_hold(4'b0001, "R8 hold ch1");
        ack_hold(4'b0000, "R8 hold ch1 drop");
        ack_end("R9 release");
        ack_begin(4'b0011, "R5 fixed ch0");
        ack_end("R9 release ch0");

        // R11 masked channels ignored
        reg_wr(0, 8'h0C);
        int_chk(4'b0011, 1'b0, "R11 R3 masked int");
        ack_begin(4'b1111, "R11 masked win ch2");
        ack_end("R9 release ch2");

        // R6 rotating priority
        reg_wr(0, 8'h0F);
        reg_wr(CTRL, 8'h03);
        for (int r = 0; r < 5; r++) begin
            ack_begin(4'b1111, "R6 rotate all");
            ack_end("R9 release rotate");
        end
        ack_begin(4'b0101, "R6 rotate sparse");
        ack_end("R9 release sparse");
        ack_begin(4'b0101, "R6 rotate sparse wrap");
        ack_end("R9 release sparse wrap");

        // R9 read during idle still enables output
        reg_rd(2, 8'd17, "R9 R2 idle read");

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule